// File: doc/BRIEF.md
# SDRAM Column Burst Sequencer

This block is the column-side burst engine of a synchronous DRAM device. A command decoder hands it one command per clock (idle, read, write or stop) together with a bank, a starting column and an auto-precharge flag. For every cycle of a burst it names the column and bank that the storage array must touch. It raises a write-capture enable or an array-read enable for that beat. For reads, it raises a data-drive enable delayed by the programmed CAS latency.

Only one burst runs at a time. A new read or write replaces the burst in flight on the same clock, and a stop command ends it. Fixed-length bursts wrap inside their aligned column block. Full-page bursts walk the whole 256-column page, wrap past the last column and run until they are stopped. When a burst that carried the auto-precharge flag finishes on its own or is stopped, the block requests a row precharge for that bank.

Top module: `sdram_burst_seq`

## Requirements
- R1: While `rst_n` is low, and right after its release with idle commands, every output is zero.
- R2: Command codes are 0 idle, 1 read, 2 write and 3 stop. A write raises `wr_en_o` in its own cycle with `col_o`/`bank_o` equal to the command's column/bank, and then once per following cycle until the burst length is used up. In any cycle without a beat, `wr_en_o`, `rd_en_o`, `col_o` and `bank_o` are zero.
- R3: `bl_code_i` values 0 to 3 select 1, 2, 4 or 8 beats, latched with the command. Beat k uses column `(start & ~(L-1)) | ((start + k) & (L-1))`, so the columns wrap inside the L-aligned block.
- R4: `bl_code_i` values 4 to 7 select a full-page burst. Its column increments modulo 256, so 255 is followed by 0, and the burst continues until a stop, read or write command arrives.
- R5: A write issued during a write burst, or in the cycle right after its last beat, takes effect in its own cycle with its own column. It leaves no idle cycle and gives no further beat to the earlier burst.
- R6: A read raises `rd_en_o` for each beat with the beat's column. `dq_oe_o` is high exactly CL cycles after each read beat, where CL is 2 when `cl3_i` is 0 and 3 when `cl3_i` is 1.
- R7: A stop command produces no beat in its own cycle and stops the burst. After a stop that ends a read, `dq_oe_o` stays high for CL-1 further cycles and then goes low.
- R8: A read issued during a write burst, or a write issued during a read burst, ends the earlier burst at once. The new burst owns the beat of that cycle.
- R9: A burst with the auto-precharge flag set makes `pre_req_o` pulse for one cycle, with `pre_bank_o` equal to its bank. The pulse comes in the cycle after its last natural beat or after the stop command that ends it. No pulse follows a burst without the flag or one replaced by a new read or write. `pre_bank_o` is zero when `pre_req_o` is low.
- R10: A stop command while no burst is active has no effect on any output.
- R11: `wr_en_o` and `rd_en_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_i | input | 2 | Decoded command: 0 idle, 1 read, 2 write, 3 stop |
| bank_i | input | 2 | Bank of a read or write |
| col_i | input | 8 | Starting column of a read or write |
| ap_i | input | 1 | Auto-precharge flag of a read or write |
| bl_code_i | input | 3 | Burst length code (0..3 fixed 1/2/4/8, 4..7 full page) |
| cl3_i | input | 1 | CAS latency select: 0 for 2, 1 for 3 |
| col_o | output | 8 | Column of the current beat |
| bank_o | output | 2 | Bank of the current beat |
| wr_en_o | output | 1 | Capture the input data beat into the array |
| rd_en_o | output | 1 | Read the array at the current column |
| dq_oe_o | output | 1 | Drive output data this cycle |
| pre_req_o | output | 1 | Request a precharge of `pre_bank_o` |
| pre_bank_o | output | 2 | Bank to precharge |

## Verification
Some properties are checked on every cycle. Write and read enables never overlap. A new write always claims its own cycle and column. A stop command never carries a beat, and an idle after a stop stays quiet. The drive enable follows each read beat by exactly the selected latency. Other behaviour can only be shown by the scenarios. This covers the column order inside aligned blocks, the full-page wrap from 255 to 0, and the exact beat counts of truncated bursts. It also covers the CL-dependent read tail after a stop, and whether a precharge request appears or is withheld for natural, stopped and replaced bursts.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;
    parameter int unsigned SEQ_COL_W  = 8;
    parameter int unsigned SEQ_BANK_W = 2;
    parameter int unsigned SEQ_REM_W  = 4;

    typedef enum logic [1:0] {
        CMD_IDLE  = 2'd0,
        CMD_READ  = 2'd1,
        CMD_WRITE = 2'd2,
        CMD_STOP  = 2'd3
    } seq_cmd_e;

    typedef struct packed {
        logic                  active;
        logic                  is_wr;
        logic                  full;
        logic                  ap;
        logic [SEQ_BANK_W-1:0] bank;
        logic [SEQ_COL_W-1:0]  col;
        logic [SEQ_COL_W-1:0]  mask;
        logic [SEQ_REM_W-1:0]  rem;
        logic                  pre;
        logic [SEQ_BANK_W-1:0] pre_bank;
    } burst_st_t;

    // Next column: bits under the mask count up and wrap, the rest hold.
    function automatic logic [SEQ_COL_W-1:0] col_step(
        input logic [SEQ_COL_W-1:0] col,
        input logic [SEQ_COL_W-1:0] mask
    );
        logic [SEQ_COL_W-1:0] inc;
        inc = col + SEQ_COL_W'(1);
        return (col & ~mask) | (inc & mask);
    endfunction
endpackage

// File: rtl/seq_burst_ctrl.sv
module seq_burst_ctrl
    import sdram_seq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            cmd_i,
    input  logic [SEQ_BANK_W-1:0] bank_i,
    input  logic [SEQ_COL_W-1:0]  col_i,
    input  logic                  ap_i,
    input  logic [2:0]            bl_code_i,
    output logic [SEQ_COL_W-1:0]  col_o,
    output logic [SEQ_BANK_W-1:0] bank_o,
    output logic                  wr_en_o,
    output logic                  rd_en_o,
    output logic                  pre_req_o,
    output logic [SEQ_BANK_W-1:0] pre_bank_o
);
    burst_st_t st_d, st_q;
    seq_cmd_e  cmd;
    logic                  beat, beat_wr;
    logic [SEQ_COL_W-1:0]  beat_col;
    logic [SEQ_BANK_W-1:0] beat_bank;
    logic [SEQ_REM_W-1:0]  new_len;
    logic                  new_full;

    assign cmd      = seq_cmd_e'(cmd_i);
    assign new_full = bl_code_i[2];
    assign new_len  = SEQ_REM_W'(1) << bl_code_i[1:0];

    always_comb begin
        st_d          = st_q;
        st_d.pre      = 1'b0;
        st_d.pre_bank = '0;
        beat          = 1'b0;
        beat_wr       = 1'b0;
        beat_col      = '0;
        beat_bank     = '0;
        if (cmd == CMD_READ || cmd == CMD_WRITE) begin
            // a new access owns this cycle's beat and replaces any burst
            beat        = 1'b1;
            beat_wr     = (cmd == CMD_WRITE);
            beat_col    = col_i;
            beat_bank   = bank_i;
            st_d.full   = new_full;
            st_d.mask   = new_full ? '1 : SEQ_COL_W'(new_len - SEQ_REM_W'(1));
            st_d.active = new_full || (new_len != SEQ_REM_W'(1));
            st_d.is_wr  = beat_wr;
            st_d.ap     = ap_i;
            st_d.bank   = bank_i;
            st_d.col    = col_step(col_i, st_d.mask);
            st_d.rem    = new_len - SEQ_REM_W'(1);
            if (!st_d.active && ap_i) begin
                st_d.pre      = 1'b1;
                st_d.pre_bank = bank_i;
            end
        end else if (cmd == CMD_STOP) begin
            st_d.active = 1'b0;
            if (st_q.active && st_q.ap) begin
                st_d.pre      = 1'b1;
                st_d.pre_bank = st_q.bank;
            end
        end else if (st_q.active) begin
            beat      = 1'b1;
            beat_wr   = st_q.is_wr;
            beat_col  = st_q.col;
            beat_bank = st_q.bank;
            st_d.col  = col_step(st_q.col, st_q.mask);
            if (!st_q.full) begin
                st_d.rem = st_q.rem - SEQ_REM_W'(1);
                if (st_q.rem == SEQ_REM_W'(1)) begin
                    st_d.active = 1'b0;
                    if (st_q.ap) begin
                        st_d.pre      = 1'b1;
                        st_d.pre_bank = st_q.bank;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign col_o      = beat_col;
    assign bank_o     = beat_bank;
    assign wr_en_o    = beat && beat_wr;
    assign rd_en_o    = beat && !beat_wr;
    assign pre_req_o  = st_q.pre;
    assign pre_bank_o = st_q.pre_bank;

    // R11: never both directions in one cycle
    a_r11_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_o && rd_en_o));
    // R5: a write claims its own cycle and column
    a_r5_write_claims_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == 2'd2) |-> (wr_en_o && col_o == col_i && bank_o == bank_i));
    // R7: a stop carries no beat
    a_r7_stop_no_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == 2'd3) |-> (!wr_en_o && !rd_en_o));
    // R7: idle after a stop stays quiet
    a_r7_quiet_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cmd_i) == 2'd3 && cmd_i == 2'd0) |-> (!wr_en_o && !rd_en_o));
endmodule

// File: rtl/seq_read_latency.sv
module seq_read_latency #(
    parameter int unsigned MAX_CL = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_en_i,
    input  logic cl3_i,
    output logic dq_oe_o
);
    logic [MAX_CL-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = {sr_q[MAX_CL-2:0], rd_en_i};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    // array read at cycle t appears at sr_q[k] in cycle t+1+k
    assign dq_oe_o = cl3_i ? sr_q[MAX_CL-1] : sr_q[MAX_CL-2];

    // R6: drive enable follows a read beat by the selected latency
    a_r6_latency_two: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && !cl3_i) |-> ##2 dq_oe_o);
    a_r6_latency_three: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && cl3_i) |-> ##3 dq_oe_o);
endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq
    import sdram_seq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            cmd_i,
    input  logic [SEQ_BANK_W-1:0] bank_i,
    input  logic [SEQ_COL_W-1:0]  col_i,
    input  logic                  ap_i,
    input  logic [2:0]            bl_code_i,
    input  logic                  cl3_i,
    output logic [SEQ_COL_W-1:0]  col_o,
    output logic [SEQ_BANK_W-1:0] bank_o,
    output logic                  wr_en_o,
    output logic                  rd_en_o,
    output logic                  dq_oe_o,
    output logic                  pre_req_o,
    output logic [SEQ_BANK_W-1:0] pre_bank_o
);
    logic rd_beat;

    seq_burst_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_i      (cmd_i),
        .bank_i     (bank_i),
        .col_i      (col_i),
        .ap_i       (ap_i),
        .bl_code_i  (bl_code_i),
        .col_o      (col_o),
        .bank_o     (bank_o),
        .wr_en_o    (wr_en_o),
        .rd_en_o    (rd_beat),
        .pre_req_o  (pre_req_o),
        .pre_bank_o (pre_bank_o)
    );

    seq_read_latency #(.MAX_CL(3)) u_lat (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en_i (rd_beat),
        .cl3_i   (cl3_i),
        .dq_oe_o (dq_oe_o)
    );

    assign rd_en_o = rd_beat;
endmodule

// File: tb/sdram_burst_seq_tb_top.sv
module sdram_burst_seq_tb_top;
    localparam int NCYC = 130;
    localparam int ASZ  = 256;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n;
    logic [1:0] cmd, bank;
    logic [7:0] col;
    logic       ap, cl3;
    logic [2:0] bl;
    logic [7:0] col_o;
    logic [1:0] bank_o, pre_bank_o;
    logic       wr_en_o, rd_en_o, dq_oe_o, pre_req_o;

    sdram_burst_seq dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .bank_i(bank), .col_i(col),
        .ap_i(ap), .bl_code_i(bl), .cl3_i(cl3), .col_o(col_o), .bank_o(bank_o),
        .wr_en_o(wr_en_o), .rd_en_o(rd_en_o), .dq_oe_o(dq_oe_o),
        .pre_req_o(pre_req_o), .pre_bank_o(pre_bank_o)
    );

    // stimulus schedule and expected-result scoreboard, indexed by cycle
    logic [1:0] s_cmd [ASZ];
    logic [1:0] s_bank[ASZ];
    logic [7:0] s_col [ASZ];
    logic       s_ap  [ASZ];
    logic       e_wr[ASZ], e_rd[ASZ], e_oe[ASZ], e_pre[ASZ];
    logic [7:0] e_col[ASZ];
    logic [1:0] e_bank[ASZ], e_pbank[ASZ];
    string      e_tag[ASZ];

    int checks = 0, errors = 0;
    bit done = 0;

    function automatic int cl_of(int c);
        return (c >= 60) ? 3 : 2;
    endfunction

    function automatic int bl_of(int c);
        if (c < 60)  return 2;
        if (c < 66)  return 0;
        if (c < 90)  return 3;
        if (c < 110) return 4;
        return 2;
    endfunction

    task automatic issue(int c, int k, int bk, int cv, bit apv);
        s_cmd[c] = 2'(k); s_bank[c] = 2'(bk); s_col[c] = 8'(cv); s_ap[c] = apv;
    endtask

    // driver-side expectation push: nb beats of a burst started at c0
    task automatic expect_burst(int c0, bit wr, int bk, int cv, int nb, string tag);
        int code = bl_of(c0);
        int mask = (code >= 4) ? 255 : (1 << code) - 1;
        for (int i = 0; i < nb; i++) begin
            int c = c0 + i;
            e_wr[c]   = wr;
            e_rd[c]   = !wr;
            e_col[c]  = 8'(((cv & ~mask) | ((cv + i) & mask)) & 255);
            e_bank[c] = 2'(bk);
            e_tag[c]  = tag;
            if (!wr) begin
                e_oe[c + cl_of(c0)]  = 1'b1;
                e_tag[c + cl_of(c0)] = tag;
            end
        end
    endtask

    task automatic expect_pre(int c, int bk, string tag);
        e_pre[c] = 1'b1; e_pbank[c] = 2'(bk); e_tag[c] = tag;
    endtask

    task automatic compare(int c, string tag);
        logic [22:0] got, exp;
        got = {wr_en_o, rd_en_o, dq_oe_o, pre_req_o, pre_bank_o, bank_o, col_o, 7'd0};
        exp = {e_wr[c], e_rd[c], e_oe[c], e_pre[c], e_pbank[c], e_bank[c], e_col[c], 7'd0};
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s cycle %0d: got wr/rd/oe/pre/pbank/bank/col=%b/%b/%b/%b/%0d/%0d/%h expected %b/%b/%b/%b/%0d/%0d/%h",
                tag, c, wr_en_o, rd_en_o, dq_oe_o, pre_req_o, pre_bank_o, bank_o, col_o,
                e_wr[c], e_rd[c], e_oe[c], e_pre[c], e_pbank[c], e_bank[c], e_col[c]);
        end
    endtask

    initial begin
        for (int i = 0; i < ASZ; i++) begin
            s_cmd[i] = 2'd0; s_bank[i] = 2'd0; s_col[i] = 8'd0; s_ap[i] = 1'b0;
            e_wr[i] = 0; e_rd[i] = 0; e_oe[i] = 0; e_pre[i] = 0;
            e_col[i] = 0; e_bank[i] = 0; e_pbank[i] = 0; e_tag[i] = "R2";
        end
        // CL2, length 4
        issue(2, 2, 1, 'h0E, 1);  expect_burst(2, 1, 1, 'h0E, 4, "R3");  expect_pre(6, 1, "R9");
        issue(10, 2, 0, 'h20, 0); expect_burst(10, 1, 0, 'h20, 2, "R5");
        issue(12, 2, 2, 'h40, 0); expect_burst(12, 1, 2, 'h40, 4, "R5");
        issue(16, 2, 3, 'h50, 0); expect_burst(16, 1, 3, 'h50, 4, "R5");
        issue(22, 1, 1, 'h33, 0); expect_burst(22, 0, 1, 'h33, 4, "R6");
        issue(30, 1, 0, 'h10, 0); expect_burst(30, 0, 0, 'h10, 2, "R7");
        issue(32, 3, 0, 0, 0);
        issue(38, 2, 0, 'h60, 0); expect_burst(38, 1, 0, 'h60, 2, "R8");
        issue(40, 1, 1, 'h70, 0); expect_burst(40, 0, 1, 'h70, 4, "R8");
        issue(50, 1, 2, 'h80, 0); expect_burst(50, 0, 2, 'h80, 2, "R8");
        issue(52, 2, 2, 'h90, 0); expect_burst(52, 1, 2, 'h90, 4, "R8");
        // CL3, single beats with auto precharge, back to back
        issue(62, 2, 1, 'h05, 1); expect_burst(62, 1, 1, 'h05, 1, "R9"); expect_pre(63, 1, "R9");
        issue(63, 2, 2, 'h06, 1); expect_burst(63, 1, 2, 'h06, 1, "R9"); expect_pre(64, 2, "R9");
        // length 8 read, natural end with auto precharge
        issue(66, 1, 3, 'hA1, 1); expect_burst(66, 0, 3, 'hA1, 8, "R3"); expect_pre(74, 3, "R9");
        issue(80, 1, 0, 'h20, 0); expect_burst(80, 0, 0, 'h20, 3, "R7");
        issue(83, 3, 0, 0, 0);
        // full page
        issue(90, 2, 1, 'hFD, 1); expect_burst(90, 1, 1, 'hFD, 5, "R4");
        issue(95, 3, 0, 0, 0);    expect_pre(96, 1, "R9");
        issue(100, 1, 2, 'hFE, 0); expect_burst(100, 0, 2, 'hFE, 3, "R4");
        issue(103, 3, 0, 0, 0);
        // stop while idle
        issue(110, 3, 1, 'h55, 1);
        for (int i = 110; i < 113; i++) e_tag[i] = "R10";
        // auto-precharge write replaced by a read: no request
        issue(114, 2, 0, 'h08, 1); expect_burst(114, 1, 0, 'h08, 2, "R9");
        issue(116, 1, 0, 'h0C, 0); expect_burst(116, 0, 0, 'h0C, 4, "R8");
        for (int i = 116; i < 124; i++) if (!e_oe[i] && !e_rd[i]) e_tag[i] = "R9";
    end

    initial begin
        rst_n = 1'b0; cmd = 2'd0; bank = 2'd0; col = 8'd0; ap = 1'b0; bl = 3'd2; cl3 = 1'b0;
        repeat (3) @(negedge clk);
        #2;
        checks++;
        if ({wr_en_o, rd_en_o, dq_oe_o, pre_req_o, pre_bank_o, bank_o, col_o} !== 15'd0) begin
            errors++;
            $display("FAIL R1 reset outputs: got %b expected all zero",
                {wr_en_o, rd_en_o, dq_oe_o, pre_req_o, pre_bank_o, bank_o, col_o});
        end
        @(negedge clk);
        rst_n = 1'b1;
        for (int c = 0; c < NCYC; c++) begin
            @(negedge clk);
            cmd  = s_cmd[c];
            bank = s_bank[c];
            col  = s_col[c];
            ap   = s_ap[c];
            bl   = 3'(bl_of(c));
            cl3  = (cl_of(c) == 3);
            #2;
            compare(c, (c < 2) ? "R1" : e_tag[c]);
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #20000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, got hang expected end");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule